// File: doc/BRIEF.md
# Dual-Port Demultiplexing Sample Formatter

This block is the digital back end of a fast sampling converter. Every input clock it takes one sample code and an overrange flag, clamps and formats the code, and delays it through a fixed pipeline. It then deals consecutive samples out to two output ports, A and B, so each port runs at half the input rate. Each port has its own overrange bit. A half-rate data clock comes out beside the data so that downstream logic can latch either port.

A sync input sets which port gets a given sample. While sync is high, every output freezes. The first clock edge that sees sync low again starts a new port phase: the sample taken on that edge goes to port B and the next one goes to port A. A mode pin selects between two timings. In interleaved timing the ports update on alternate cycles. In parallel timing port A gets one extra cycle of delay so that both ports update on the same edge. A format pin selects offset-binary or two's complement codes.

Top module: `demux_formatter`

## Requirements
- R1: When `smp_ovr` is 1, the code is clamped before formatting. If `smp_code` bit 9 is 1 the offset-binary result is 1023, and if it is 0 the result is 0. The port's overrange bit comes out 1 together with that sample. A sample with `smp_ovr` 0 keeps its code and comes out with overrange 0.
- R2: With `twos_sel` 1 at capture, the output code is the offset-binary code with bit 9 inverted (offset 512 becomes 0). With `twos_sel` 0 the code passes unchanged. The select is captured with each sample.
- R3: Consecutive samples go to alternating ports. Each port updates at most every second input cycle, and the port that is not updated holds its value.
- R4: The first rising edge at which `sync_hold` is low after it was high captures a sample that goes to port B. The sample on the following edge goes to port A, and the pattern keeps alternating after that.
- R5: After reset, with no sync event, the first sample captured goes to port B.
- R6: In interleaved mode, a sample captured on edge k appears on its port right after edge k+6.
- R7: In parallel mode, a port-B sample captured on edge k appears right after edge k+6. On the same edge, port A loads the sample captured on edge k-1 (latency 7). Neither port changes on the cycles in between.
- R8: On any edge where `sync_hold` is high, `pa_code`, `pa_ovr`, `pb_code`, `pb_ovr` and `dclk_out` keep their values.
- R9: `ilv_sel` (1 = interleaved, 0 = parallel) is latched only on edges where `sync_hold` is high. Changes while sync is low have no effect. The mode after reset is interleaved.
- R10: `dclk_out` goes to 1 on each edge where a port-B sample reaches the output stage and to 0 on each edge where a port-A sample reaches that depth. This gives a half-rate clock in phase with port-B updates.
- R11: While `rst_n` is low, all port codes, overrange bits and `dclk_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_code | input | 10 | Offset-binary sample code |
| smp_ovr | input | 1 | Sample is out of range |
| sync_hold | input | 1 | High freezes outputs; the falling edge sets the port phase |
| twos_sel | input | 1 | 1 = two's complement output, 0 = offset binary |
| ilv_sel | input | 1 | 1 = interleaved timing, 0 = parallel timing |
| pa_code | output | 10 | Port A code |
| pa_ovr | output | 1 | Port A overrange |
| pb_code | output | 10 | Port B code |
| pb_ovr | output | 1 | Port B overrange |
| dclk_out | output | 1 | Half-rate data clock |

## Verification
A table of sixteen sample vectors is run through both timing modes. The table mixes midscale, the two end codes, clamps with overrange in both directions, and bit patterns under both formats. Because the codes are all distinct, a sample that lands on the wrong port or in the wrong cycle shows up as a value mismatch, not as a silent repeat. A count ramp after reset without any sync separates the default phase from the synced phase. The two passes begin on opposite pipeline phases, so a port assignment that ignored the sync edge would fail in at least one of them. A frozen window with a changing input shows the outputs hold, and flipping the mode pin while sync is low shows that it is ignored.

// File: rtl/demux_fmt_pkg.sv
package demux_fmt_pkg;
   typedef enum logic {
      LANE_A = 1'b0,
      LANE_B = 1'b1
   } lane_e;
endpackage

// File: rtl/dmx_shaper.sv
module dmx_shaper #(
   parameter int DW = 10
) (
   input  logic [DW-1:0] code_i,
   input  logic          ovr_i,
   input  logic          twos_i,
   output logic [DW-1:0] code_o,
   output logic          ovr_o
);
   logic [DW-1:0] clamped;

   always_comb begin
      clamped = ovr_i ? {DW{code_i[DW-1]}} : code_i;
      code_o  = twos_i ? {~clamped[DW-1], clamped[DW-2:0]} : clamped;
      ovr_o   = ovr_i;
   end
endmodule

// File: rtl/dmx_lane_tag.sv
module dmx_lane_tag
   import demux_fmt_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sync_i,
   input  logic  ilv_i,
   output lane_e lane_o,
   output logic  ilv_q
);
   logic  sync_q;
   lane_e last_lane;
   logic  resync;

   assign resync = !sync_i && sync_q;

   always_comb begin
      if (resync)                lane_o = LANE_B;
      else if (last_lane == LANE_B) lane_o = LANE_A;
      else                       lane_o = LANE_B;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q    <= 1'b0;
         last_lane <= LANE_A;
         ilv_q     <= 1'b1;
      end else begin
         sync_q    <= sync_i;
         last_lane <= lane_o;
         if (sync_i) ilv_q <= ilv_i;
      end
   end
endmodule

// File: rtl/dmx_delay.sv
module dmx_delay #(
   parameter int W     = 12,
   parameter int DEPTH = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [W-1:0]            d,
   output logic [DEPTH-1:0][W-1:0] q
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= '0;
            else        q[i] <= d;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= '0;
            else        q[i] <= q[i-1];
         end
      end
   end
endmodule

// File: rtl/dmx_ports.sv
module dmx_ports #(
   parameter int DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_i,
   input  logic          ilv_i,
   input  logic [DW+1:0] near_i,
   input  logic [DW+1:0] far_i,
   output logic [DW-1:0] pa_code,
   output logic          pa_ovr,
   output logic [DW-1:0] pb_code,
   output logic          pb_ovr,
   output logic          dclk_out
);
   logic near_is_b;
   assign near_is_b = near_i[DW+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_code  <= '0;
         pa_ovr   <= 1'b0;
         pb_code  <= '0;
         pb_ovr   <= 1'b0;
         dclk_out <= 1'b0;
      end else if (!hold_i) begin
         dclk_out <= near_is_b;
         if (ilv_i) begin
            if (near_is_b) begin
               pb_code <= near_i[DW-1:0];
               pb_ovr  <= near_i[DW];
            end else begin
               pa_code <= near_i[DW-1:0];
               pa_ovr  <= near_i[DW];
            end
         end else if (near_is_b) begin
            pb_code <= near_i[DW-1:0];
            pb_ovr  <= near_i[DW];
            pa_code <= far_i[DW-1:0];
            pa_ovr  <= far_i[DW];
         end
      end
   end
endmodule

// File: rtl/demux_formatter.sv
module demux_formatter
   import demux_fmt_pkg::*;
#(
   parameter int DW       = 10,
   parameter int BASE_LAT = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] smp_code,
   input  logic          smp_ovr,
   input  logic          sync_hold,
   input  logic          twos_sel,
   input  logic          ilv_sel,
   output logic [DW-1:0] pa_code,
   output logic          pa_ovr,
   output logic [DW-1:0] pb_code,
   output logic          pb_ovr,
   output logic          dclk_out
);
   localparam int EW    = DW + 2;
   localparam int DEPTH = BASE_LAT + 1;

   if (DW < 2) begin : g_bad_dw
      $error("demux_formatter: DW must be at least 2");
   end
   if (BASE_LAT < 1) begin : g_bad_lat
      $error("demux_formatter: BASE_LAT must be at least 1");
   end

   logic [DW-1:0]            shp_code;
   logic                     shp_ovr;
   lane_e                    cap_lane;
   logic                     ilv_q;
   logic [DEPTH-1:0][EW-1:0] taps;
   logic [EW-1:0]            entry;

   assign entry = {cap_lane, shp_ovr, shp_code};

   dmx_shaper #(.DW(DW)) u_shp (
      .code_i (smp_code),
      .ovr_i  (smp_ovr),
      .twos_i (twos_sel),
      .code_o (shp_code),
      .ovr_o  (shp_ovr)
   );

   dmx_lane_tag u_tag (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_hold),
      .ilv_i  (ilv_sel),
      .lane_o (cap_lane),
      .ilv_q  (ilv_q)
   );

   dmx_delay #(.W(EW), .DEPTH(DEPTH)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (entry),
      .q     (taps)
   );

   dmx_ports #(.DW(DW)) u_prt (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_i   (sync_hold),
      .ilv_i    (ilv_q),
      .near_i   (taps[BASE_LAT-1]),
      .far_i    (taps[BASE_LAT]),
      .pa_code  (pa_code),
      .pa_ovr   (pa_ovr),
      .pb_code  (pb_code),
      .pb_ovr   (pb_ovr),
      .dclk_out (dclk_out)
   );
endmodule

// File: rtl/dmx_checker.sv
module dmx_checker #(
   parameter int DW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sync_hold,
   input logic          ilv_q,
   input logic [DW-1:0] pa_code,
   input logic          pa_ovr,
   input logic [DW-1:0] pb_code,
   input logic          pb_ovr,
   input logic          dclk_out
);
   assert_hold_static_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hold |=> ($stable(pa_code) && $stable(pb_code) && $stable(pa_ovr)
                     && $stable(pb_ovr) && $stable(dclk_out)));

   assert_clamp_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pa_ovr |-> (pa_code[DW-2:0] == '0 || pa_code[DW-2:0] == '1));

   assert_clamp_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pb_ovr |-> (pb_code[DW-2:0] == '0 || pb_code[DW-2:0] == '1));

   assert_par_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ilv_q && !$stable(pa_code)) |-> dclk_out);

   assert_mode_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_hold |=> $stable(ilv_q));
endmodule

bind demux_formatter dmx_checker #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_hold (sync_hold),
   .ilv_q     (ilv_q),
   .pa_code   (pa_code),
   .pa_ovr    (pa_ovr),
   .pb_code   (pb_code),
   .pb_ovr    (pb_ovr),
   .dclk_out  (dclk_out)
);

// File: tb/sim_demux_formatter.sv
module sim_demux_formatter;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [9:0] smp_code;
   logic       smp_ovr;
   logic       sync_hold;
   logic       twos_sel;
   logic       ilv_sel;
   logic [9:0] pa_code;
   logic       pa_ovr;
   logic [9:0] pb_code;
   logic       pb_ovr;
   logic       dclk_out;

   int nchk = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   demux_formatter u0 (
      .clk(clk), .rst_n(rst_n), .smp_code(smp_code), .smp_ovr(smp_ovr),
      .sync_hold(sync_hold), .twos_sel(twos_sel), .ilv_sel(ilv_sel),
      .pa_code(pa_code), .pa_ovr(pa_ovr), .pb_code(pb_code), .pb_ovr(pb_ovr),
      .dclk_out(dclk_out)
   );

   // {code_in, ovr_in, twos, exp_code, exp_ovr}
   localparam logic [22:0] VEC [16] = '{
      {10'h200, 1'b0, 1'b0, 10'h200, 1'b0},
      {10'h200, 1'b0, 1'b1, 10'h000, 1'b0},
      {10'h3FF, 1'b0, 1'b0, 10'h3FF, 1'b0},
      {10'h3FF, 1'b0, 1'b1, 10'h1FF, 1'b0},
      {10'h000, 1'b0, 1'b0, 10'h000, 1'b0},
      {10'h000, 1'b0, 1'b1, 10'h200, 1'b0},
      {10'h300, 1'b1, 1'b0, 10'h3FF, 1'b1},
      {10'h300, 1'b1, 1'b1, 10'h1FF, 1'b1},
      {10'h0A5, 1'b1, 1'b0, 10'h000, 1'b1},
      {10'h0A5, 1'b1, 1'b1, 10'h200, 1'b1},
      {10'h155, 1'b0, 1'b0, 10'h155, 1'b0},
      {10'h2AA, 1'b0, 1'b1, 10'h0AA, 1'b0},
      {10'h201, 1'b0, 1'b1, 10'h001, 1'b0},
      {10'h1FF, 1'b0, 1'b1, 10'h3FF, 1'b0},
      {10'h123, 1'b0, 1'b0, 10'h123, 1'b0},
      {10'h3C4, 1'b0, 1'b1, 10'h1C4, 1'b0}
   };
   localparam logic [9:0] FILL = 10'h0F0;

   task automatic drive(input logic [9:0] c, input logic o, input logic f);
      smp_code = c;
      smp_ovr  = o;
      twos_sel = f;
   endtask

   task automatic drive_vec(input int t);
      if (t < 16) drive(VEC[t][22:13], VEC[t][12], VEC[t][11]);
      else        drive(FILL, 1'b0, 1'b0);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int expc(input int s);
      if (s < 0 || s >= 16) return int'(FILL);
      return int'(VEC[s][10:1]);
   endfunction

   function automatic int expo(input int s);
      if (s < 0 || s >= 16) return 0;
      return int'(VEC[s][0]);
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_pass(input bit par);
      sync_hold = 1'b0;
      drive_vec(0);
      for (int t = 0; t < 24; t++) begin
         step();
         if (t >= 6) begin
            int s;
            s = t - 6;
            if (!par) begin
               if (s % 2 == 0) begin
                  chk("R4 R6 R9 R1 R2 port B code", pb_code, expc(s));
                  chk("R1 port B ovr", pb_ovr, expo(s));
                  if (s > 0) chk("R3 port A held", pa_code, expc(s - 1));
               end else begin
                  chk("R4 R6 R9 R1 R2 port A code", pa_code, expc(s));
                  chk("R1 port A ovr", pa_ovr, expo(s));
                  chk("R3 port B held", pb_code, expc(s - 1));
               end
            end else begin
               if (s % 2 == 0) begin
                  chk("R7 R4 R1 R2 port B code", pb_code, expc(s));
                  chk("R7 R1 port B ovr", pb_ovr, expo(s));
                  chk("R7 R1 R2 port A code", pa_code, expc(s - 1));
                  chk("R7 R1 port A ovr", pa_ovr, expo(s - 1));
               end else begin
                  chk("R7 port B hold", pb_code, expc(s - 1));
                  chk("R7 port A hold", pa_code, expc(s - 2));
               end
            end
            chk("R10 dclk phase", int'(dclk_out), (s % 2 == 0) ? 1 : 0);
         end
         if (!par && t == 3) ilv_sel = 1'b0;
         if (t < 23) drive_vec(t + 1);
      end
   endtask

   initial begin
      #200000;
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      logic [9:0] snap_a;
      logic [9:0] snap_b;
      logic       snap_ao;
      logic       snap_bo;
      logic       snap_d;
      rst_n     = 1'b0;
      sync_hold = 1'b0;
      ilv_sel   = 1'b1;
      drive(10'h2C3, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      chk("R11 reset pa_code", pa_code, 0);
      chk("R11 reset pb_code", pb_code, 0);
      chk("R11 reset pa_ovr", pa_ovr, 0);
      chk("R11 reset pb_ovr", pb_ovr, 0);
      chk("R11 reset dclk", dclk_out, 0);

      // default phase: first sample after reset goes to port B
      rst_n = 1'b1;
      drive(10'h101, 1'b0, 1'b0);
      for (int e = 1; e <= 9; e++) begin
         step();
         if (e == 7) begin
            chk("R5 first sample on B", pb_code, 'h101);
            chk("R5 R10 dclk high", dclk_out, 1);
         end
         if (e == 8) begin
            chk("R5 R6 second sample on A", pa_code, 'h102);
            chk("R5 R10 dclk low", dclk_out, 0);
         end
         if (e == 9) chk("R5 R3 third sample on B", pb_code, 'h103);
         drive(10'h100 + 10'(e + 1), 1'b0, 1'b0);
      end

      sync_hold = 1'b1;
      drive(FILL, 1'b0, 1'b0);
      repeat (3) step();

      run_pass(1'b0);

      // frozen window: outputs must not move while sync is high
      sync_hold = 1'b1;
      snap_a  = pa_code;
      snap_b  = pb_code;
      snap_ao = pa_ovr;
      snap_bo = pb_ovr;
      snap_d  = dclk_out;
      for (int i = 0; i < 5; i++) begin
         if (i < 4) drive(10'h3A0 + 10'(i), i[0], 1'b0);
         else       drive(FILL, 1'b0, 1'b0);
         step();
         chk("R8 pa_code frozen", pa_code, snap_a);
         chk("R8 pb_code frozen", pb_code, snap_b);
         chk("R8 ovr frozen", {pa_ovr, pb_ovr}, {snap_ao, snap_bo});
         chk("R8 dclk frozen", dclk_out, snap_d);
      end

      run_pass(1'b1);

      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule